// File: doc/BRIEF.md
# Power-Up Wake Edge Latch

This block watches the already-synchronized pins of up to four 8-bit ports and one USB controller line, and records selected edges on them as sticky wake flags. For each pin, a configuration bit picks whether a rising or a falling transition counts. A separate per-pin enable decides whether a recorded flag may request wake-up. The USB line has its own edge choice and its own flag, and it always takes part in the request.

Software reaches the block through a small register port with one write strobe, a 3-bit address and a combinational read path. Flags are read back in two forms. The raw form shows every captured edge. The masked form shows only the edges on enabled pins.

Writing ones to a flag register removes those flags. The write does not clear the flags at once. It launches a clear pulse that lasts one clock, and that pulse clears the flags on the following edge. The output `wake_req_o` asks the system to power up while any enabled pin flag or the USB flag is set.

Top module: `wake_latch_top`

## Requirements
- R1: After reset, every register address reads 0 and `wake_req_o` is low. The pin edge history also starts low.
- R2: When a pin's edge-select bit is 0, a 0-to-1 change on that pin sets its raw flag. The flag is visible at address 2 (bit i for pin i) at the first clock edge that samples the new level.
- R3: When a pin's edge-select bit is 1, a 1-to-0 change on that pin sets its raw flag with the same timing as R2.
- R4: A transition in the direction not selected leaves the flag unchanged. A pin that holds its level also leaves the flag unchanged.
- R5: A raw flag is captured whatever the pin's enable bit is. Address 3 reads the raw flags ANDed with the enable register.
- R6: Writing a mask to address 2 clears the raw flags whose mask bit is 1 and leaves the others as they are. Right after the write edge the flags still read their old value. They read cleared one clock later, because a one-cycle pulse performs the clear.
- R7: Writing a mask to address 3 clears only the flags whose mask bit is 1 and whose enable bit is 1.
- R8: If a selected edge arrives in the same cycle as the clear pulse for that bit, the edge wins and the flag stays set.
- R9: `wake_req_o` is high exactly when some raw flag with its enable bit set is 1, or when the USB flag is 1.
- R10: The USB edge select is bit 0 of address 4 (0 = rising, 1 = falling). The USB flag reads at bit 0 of address 5. Writing 1 to bit 0 of address 5 clears it with the timing of R6, and writing 0 has no effect.
- R11: Address 0 holds the per-pin edge select and address 1 holds the per-pin enable. Both read back what was written. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| reg_wen | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| pin_i | input | NUM_PORTS*PORT_W | Synchronized port pin levels, port 0 in the low bits |
| usb_i | input | 1 | Synchronized USB controller wake input |
| wake_req_o | output | 1 | Power-up wake request |

## Verification
The bench builds the block with two ports of two pins each, which gives four pin flags. At that size every edge-select value can be paired with every next pin pattern, so all rising, falling and held transitions are covered. Every combination of enable value and clear mask is also tried on the masked acknowledge. The bench places the clear pulse and a fresh edge in the same cycle to expose the priority rule. It drives the USB line through both edge settings and through a write of zero to its acknowledge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_EDGE      = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE    = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG_RAW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAG_MSK  = 3'd3;
  localparam logic [ADDR_W-1:0] A_USB_EDGE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_USB_FLAG  = 3'd5;
endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] fall_sel_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] hist_q, hist_d;
  logic [W-1:0] flag_q, flag_d;
  logic [W-1:0] evt;

  always_comb begin
    evt    = (pin_i & ~hist_q & ~fall_sel_i) | (~pin_i & hist_q & fall_sel_i);
    flag_d = (flag_q & ~clr_i) | evt;
    hist_d = pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      flag_q <= '0;
    end else begin
      hist_q <= hist_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R6: a flag only drops after a clear pulse was present
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q & ~$past(clr_i)) == '0));

  // R2: a flag only rises after a selected edge was seen
  assert_flag_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(flag_q) & flag_q & ~$past(evt)) == '0));
endmodule

// File: rtl/wake_clr_gen.sv
module wake_clr_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pulse_o
);
  logic [W-1:0] pulse_q, pulse_d;

  always_comb begin
    pulse_d = stb_i ? mask_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  // R6: without a new strobe the pulse is gone after one cycle
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> (pulse_q == '0));

  // R6: any pulse bit traces back to a strobe one cycle earlier
  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0) |-> $past(stb_i));
endmodule

// File: rtl/wake_latch_top.sv
module wake_latch_top
  import wake_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        arst_n,
  input  logic                        reg_wen,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  input  logic                        usb_i,
  output logic                        wake_req_o
);
  localparam int N = NUM_PORTS * PORT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // configuration registers
  logic [N-1:0] edge_q, edge_d, en_q, en_d;
  logic         usb_edge_q, usb_edge_d;
  logic         wr_edge, wr_en, wr_usb_edge;

  always_comb begin
    wr_edge     = reg_wen && (reg_addr == A_EDGE);
    wr_en       = reg_wen && (reg_addr == A_ENABLE);
    wr_usb_edge = reg_wen && (reg_addr == A_USB_EDGE);
    edge_d      = wr_edge     ? reg_wdata[N-1:0] : edge_q;
    en_d        = wr_en       ? reg_wdata[N-1:0] : en_q;
    usb_edge_d  = wr_usb_edge ? reg_wdata[0]     : usb_edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q     <= '0;
      en_q       <= '0;
      usb_edge_q <= 1'b0;
    end else begin
      edge_q     <= edge_d;
      en_q       <= en_d;
      usb_edge_q <= usb_edge_d;
    end
  end

  // acknowledge strobes and masks
  logic         pin_ack_stb, usb_ack_stb;
  logic [N-1:0] pin_ack_mask, pin_clr;
  logic         usb_clr;

  always_comb begin
    pin_ack_stb  = reg_wen && ((reg_addr == A_FLAG_RAW) || (reg_addr == A_FLAG_MSK));
    pin_ack_mask = (reg_addr == A_FLAG_MSK) ? (reg_wdata[N-1:0] & en_q) : reg_wdata[N-1:0];
    usb_ack_stb  = reg_wen && (reg_addr == A_USB_FLAG);
  end

  wake_clr_gen #(.W(N)) u_pin_clr (
    .clk(clk), .rst_n(rst_n), .stb_i(pin_ack_stb),
    .mask_i(pin_ack_mask), .pulse_o(pin_clr)
  );

  wake_clr_gen #(.W(1)) u_usb_clr (
    .clk(clk), .rst_n(rst_n), .stb_i(usb_ack_stb),
    .mask_i(reg_wdata[0]), .pulse_o(usb_clr)
  );

  // one edge detector per port
  logic [N-1:0] pin_flag;
  logic         usb_flag;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    wake_edge_det #(.W(PORT_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i[p*PORT_W +: PORT_W]),
      .fall_sel_i(edge_q[p*PORT_W +: PORT_W]),
      .clr_i     (pin_clr[p*PORT_W +: PORT_W]),
      .flag_o    (pin_flag[p*PORT_W +: PORT_W])
    );
  end

  wake_edge_det #(.W(1)) u_usb_det (
    .clk(clk), .rst_n(rst_n), .pin_i(usb_i), .fall_sel_i(usb_edge_q),
    .clr_i(usb_clr), .flag_o(usb_flag)
  );

  // read path and wake request
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EDGE:     reg_rdata[N-1:0] = edge_q;
      A_ENABLE:   reg_rdata[N-1:0] = en_q;
      A_FLAG_RAW: reg_rdata[N-1:0] = pin_flag;
      A_FLAG_MSK: reg_rdata[N-1:0] = pin_flag & en_q;
      A_USB_EDGE: reg_rdata[0]     = usb_edge_q;
      A_USB_FLAG: reg_rdata[0]     = usb_flag;
      default:    reg_rdata        = '0;
    endcase
  end

  assign wake_req_o = (|(pin_flag & en_q)) | usb_flag;

  // R5: the masked view never shows a disabled pin
  assert_masked_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FLAG_MSK) |-> ((reg_rdata[N-1:0] & ~en_q) == '0));

  // R11: configuration changes only on a write
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wen |=> ($stable(edge_q) && $stable(en_q) && $stable(usb_edge_q)));

  // R9: a wake request implies some flag is held
  assert_wake_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> (usb_flag || (pin_flag != '0)));
endmodule

// File: tb/tb_wake_latch_top.sv
module tb_wake_latch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int PW = 2;
  localparam int N  = NP * PW;
  localparam logic [31:0] ALL = (32'd1 << N) - 1;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] pins = '0;
  logic        usb = 1'b0;
  logic        wake;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_latch_top #(.NUM_PORTS(NP), .PORT_W(PW), .DATA_W(32)) dut (
    .clk(clk), .arst_n(arst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_i(pins),
    .usb_i(usb), .wake_req_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pins_to(input logic [N-1:0] v);
    pins = v;
    @(negedge clk);
  endtask

  task automatic fill_all();
    wr(3'd0, 32'd0);
    pins_to('0);
    pins_to(ALL[N-1:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [31:0] model;
    logic [N-1:0] prev;

    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], got); chk("R1 reset read", got, 32'd0);
    end
    chk("R1 reset wake", {31'd0, wake}, 32'd0);

    // R11: configuration readback and unused addresses
    wr(3'd0, 32'hA); rd(3'd0, got); chk("R11 edge readback", got, 32'hA);
    wr(3'd1, 32'h5); rd(3'd1, got); chk("R11 enable readback", got, 32'h5);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, got); chk("R11 addr6", got, 32'd0);
    rd(3'd7, got); chk("R11 addr7", got, 32'd0);
    rd(3'd0, got); chk("R11 edge untouched", got, 32'hA);
    rd(3'd1, got); chk("R11 enable untouched", got, 32'h5);

    // R2 R3 R4 R5: every edge select against every next pin pattern
    wr(3'd1, 32'd0);
    prev = pins;
    for (int es = 0; es < 16; es++) begin
      wr(3'd0, 32'(es));
      wr(3'd2, ALL);
      @(negedge clk);
      model = 0;
      rd(3'd2, got); chk("R6 sweep clear", got, 32'd0);
      for (int p = 0; p < 16; p++) begin
        pins_to(p[N-1:0]);
        model = model | ((32'(p) & ~32'(prev) & ~32'(es)) |
                         (~32'(p) & 32'(prev) & 32'(es))) & ALL;
        rd(3'd2, got); chk("R2 R3 R4 R5 raw flag", got, model);
        prev = p[N-1:0];
      end
    end

    // R5 R9: masked view and wake against every enable value
    for (int en = 0; en < 16; en++) begin
      wr(3'd1, 32'(en));
      rd(3'd3, got); chk("R5 masked view", got, model & 32'(en));
      rd(3'd2, got); chk("R5 raw unaffected", got, model);
      chk("R9 wake", {31'd0, wake}, {31'd0, |(model & 32'(en))});
    end

    // R6: raw acknowledge with every mask, one-cycle pulse latency
    wr(3'd1, 32'd0);
    for (int m = 0; m < 16; m++) begin
      fill_all();
      wr(3'd2, 32'(m));
      rd(3'd2, got); chk("R6 before pulse", got, ALL);
      @(negedge clk);
      rd(3'd2, got); chk("R6 after pulse", got, ALL & ~32'(m));
    end

    // R7: masked acknowledge over every enable and mask
    for (int en = 0; en < 16; en++) begin
      for (int m = 0; m < 16; m++) begin
        fill_all();
        wr(3'd1, 32'(en));
        wr(3'd3, 32'(m));
        @(negedge clk);
        rd(3'd2, got); chk("R7 raw after masked ack", got, ALL & ~(32'(m) & 32'(en)));
        rd(3'd3, got); chk("R7 masked after ack", got, ALL & ~32'(m) & 32'(en));
      end
    end

    // R8: edge in the same cycle as the clear pulse wins
    wr(3'd1, 32'd0);
    fill_all();
    wr(3'd2, ALL);
    @(negedge clk);
    pins_to('0);
    pins_to({{(N-1){1'b0}}, 1'b1});
    pins_to('0);
    rd(3'd2, got); chk("R8 setup", got, 32'd1);
    wr(3'd2, 32'h3);
    pins = {{(N-2){1'b0}}, 2'b01};
    @(negedge clk);
    rd(3'd2, got); chk("R8 edge beats clear", got, 32'd1);

    // R10: USB source
    wr(3'd2, ALL);
    wr(3'd1, 32'd0);
    @(negedge clk);
    wr(3'd4, 32'd0);
    usb = 1'b1; @(negedge clk);
    rd(3'd5, got); chk("R10 usb rising", got, 32'd1);
    chk("R9 wake from usb", {31'd0, wake}, 32'd1);
    wr(3'd5, 32'd0); @(negedge clk);
    rd(3'd5, got); chk("R10 usb write0 no effect", got, 32'd1);
    wr(3'd5, 32'd1);
    rd(3'd5, got); chk("R10 usb before pulse", got, 32'd1);
    @(negedge clk);
    rd(3'd5, got); chk("R10 usb cleared", got, 32'd0);
    chk("R9 wake idle", {31'd0, wake}, 32'd0);
    wr(3'd4, 32'd1);
    rd(3'd4, got); chk("R10 usb edge readback", got, 32'd1);
    usb = 1'b0; @(negedge clk);
    rd(3'd5, got); chk("R10 usb falling", got, 32'd1);
    wr(3'd5, 32'd1); @(negedge clk);
    usb = 1'b1; @(negedge clk);
    rd(3'd5, got); chk("R4 usb wrong edge", got, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule